// File: doc/BRIEF.md
# Opcode-Driven Instruction Framer with Register Add

This block takes a byte-wide stream of machine instructions and finds where each instruction ends. It does not assume a fixed width. The first byte of every instruction is its opcode. The two most significant opcode bits fix the length at 2, 4 or 6 bytes. The block collects that many bytes and then presents the whole instruction in a single beat. The beat carries the instruction's length and one of five format classes.

Behind the framer is a small execute stage. When the framed instruction is the two-byte add (opcode 0x1A), it adds the register named by the low nibble of the second byte into the register named by the high nibble. The sixteen 32-bit registers can be read through a debug port. No other instruction is executed.

Top module: `insn_framer`

## Requirements
- R1: While `rst` is high at a clock edge, `in_ready`, `out_valid`, `add_done`, `add_ovf` and `dbg_data` become 0. Any partly collected instruction is dropped, so the next accepted byte is taken as an opcode. Register k returns to a value made by repeating the 4-bit index k in all eight nibbles. For example, register 6 becomes 0x66666666.
- R2: Opcode bits [7:6] set the length. 00 gives 2 bytes, 01 or 10 gives 4 bytes, and 11 gives 6 bytes. `out_len` reports the length in bytes.
- R3: `out_class` encodes the format class as follows:
  - 0 (register-register) when the top bits are 00.
  - 2 (register-indexed-storage) when they are 01.
  - 1 (register-storage) when they are 10 and bit 5 is 0.
  - 3 (storage-immediate) when they are 10 and bit 5 is 1.
  - 4 (storage-storage) when they are 11.
- R4: `out_valid` is high for exactly one cycle: the cycle after the clock edge that accepted the last byte of an instruction. In that cycle `out_insn[47:40]` holds the opcode and each later byte occupies the next lower byte lane. Byte lanes beyond the instruction's length read 0.
- R5: A byte is taken only at an edge where both `in_valid` and `in_ready` are high. Idle cycles between bytes lose nothing. `in_ready` rises one cycle after reset is released and then stays high.
- R6: An instruction with opcode 0x1A and second byte 0xAB writes reg[A] + reg[B], modulo 2^32, into reg[A]. The write lands at the clock edge that ends the `out_valid` cycle. Any other opcode, including other register-register opcodes, leaves every register unchanged.
- R7: `add_done` pulses in the cycle after the `out_valid` cycle of each add. In that same cycle `add_ovf` is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it. At all other times `add_ovf` is 0.
- R8: `dbg_data` shows the register selected by `dbg_sel` at the previous clock edge. A register written at that edge shows its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Framer can take a byte |
| out_valid | output | 1 | One-cycle strobe for a framed instruction |
| out_insn | output | 48 | Framed instruction, opcode in the top byte |
| out_len | output | 3 | Instruction length in bytes |
| out_class | output | 3 | Format class code |
| dbg_sel | input | 4 | Debug register index |
| dbg_data | output | 32 | Selected register value, one cycle late |
| add_done | output | 1 | An add has just been written |
| add_ovf | output | 1 | Signed overflow of that add |

## Verification
The bench uses the default parameters: 8-bit bytes, lengths of 2, 4 and 6, and sixteen 32-bit registers. With these values every length and class is reachable from a handful of opcodes. The nibble-pattern register seeds put positive and negative operands side by side, so an add can overflow in either direction within a few instructions. The debug index sweeps continuously, so each register is compared against the model every sixteen cycles. Stalls between bytes, back-to-back instructions and a reset in the middle of an instruction exercise the byte counter.

// File: rtl/insn_framer_pkg.sv
package insn_framer_pkg;
  typedef enum logic [2:0] {
    FMT_RR = 3'd0,
    FMT_RS = 3'd1,
    FMT_RX = 3'd2,
    FMT_SI = 3'd3,
    FMT_SS = 3'd4
  } fmt_e;
endpackage

// File: rtl/insn_length_lookup.sv
module insn_length_lookup
  import insn_framer_pkg::*;
#(
  parameter int SHORT_LEN = 2,
  parameter int MID_LEN   = 4,
  parameter int LONG_LEN  = 6,
  localparam int LEN_W    = $clog2(LONG_LEN + 1)
) (
  input  logic [2:0]       sel,   // opcode bits [top:top-2]
  output logic [LEN_W-1:0] len,
  output fmt_e             fmt
);
  always_comb begin
    case (sel[2:1])
      2'b00: begin len = LEN_W'(SHORT_LEN); fmt = FMT_RR; end
      2'b01: begin len = LEN_W'(MID_LEN);   fmt = FMT_RX; end
      2'b10: begin len = LEN_W'(MID_LEN);   fmt = sel[0] ? FMT_SI : FMT_RS; end
      default: begin len = LEN_W'(LONG_LEN); fmt = FMT_SS; end
    endcase
  end

  // R3: only the storage-storage class carries the longest length
  always_comb begin
    assert_len_class_R3: assert ((fmt == FMT_SS) == (len == LEN_W'(LONG_LEN)));
  end
endmodule

// File: rtl/insn_assembler.sv
module insn_assembler
  import insn_framer_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int SHORT_LEN = 2,
  parameter int MID_LEN   = 4,
  parameter int LONG_LEN  = 6,
  localparam int LEN_W    = $clog2(LONG_LEN + 1),
  localparam int INSN_W   = LONG_LEN * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [INSN_W-1:0] out_insn,
  output logic [LEN_W-1:0]  out_len,
  output fmt_e              out_class
);
  logic [LEN_W-1:0]  cnt_q, need_q, lk_len;
  fmt_e              cls_q, lk_fmt;
  logic [INSN_W-1:0] buf_q, placed;
  logic              ready_q, accept, last_byte;

  insn_length_lookup #(
    .SHORT_LEN(SHORT_LEN), .MID_LEN(MID_LEN), .LONG_LEN(LONG_LEN)
  ) u_lookup (
    .sel(in_data[BYTE_W-1 -: 3]),
    .len(lk_len),
    .fmt(lk_fmt)
  );

  // steer the incoming byte into the lane given by the byte count
  for (genvar i = 0; i < LONG_LEN; i++) begin : g_lane
    assign placed[INSN_W-1-i*BYTE_W -: BYTE_W] =
      (cnt_q == LEN_W'(i)) ? in_data : '0;
  end

  assign in_ready  = ready_q;
  assign accept    = in_valid && ready_q;
  assign last_byte = (cnt_q != '0) && (cnt_q == need_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      cnt_q     <= '0;
      need_q    <= '0;
      cls_q     <= FMT_RR;
      buf_q     <= '0;
      out_valid <= 1'b0;
      out_insn  <= '0;
      out_len   <= '0;
      out_class <= FMT_RR;
    end else begin
      ready_q   <= 1'b1;
      out_valid <= 1'b0;
      if (accept) begin
        if (cnt_q == '0) begin
          buf_q  <= placed;
          need_q <= lk_len;
          cls_q  <= lk_fmt;
          cnt_q  <= LEN_W'(1);
        end else if (last_byte) begin
          out_valid <= 1'b1;
          out_insn  <= buf_q | placed;
          out_len   <= need_q;
          out_class <= cls_q;
          cnt_q     <= '0;
        end else begin
          buf_q <= buf_q | placed;
          cnt_q <= cnt_q + LEN_W'(1);
        end
      end
    end
  end

  // R4: a strobe never lasts two cycles (shortest instruction has 2 bytes)
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2: mid-instruction count stays below the length taken from the opcode
  assert_cnt_below_need_R2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (cnt_q < need_q));

  // R5: ready is up one cycle after reset release
  assert_ready_after_reset_R5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);
endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
  parameter int REG_COUNT = 16,
  parameter int REG_W     = 32,
  localparam int IDX_W    = $clog2(REG_COUNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [REG_W-1:0] rd_a,
  output logic [REG_W-1:0] rd_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] dbg_sel,
  output logic [REG_W-1:0] dbg_data
);
  logic [REG_W-1:0] mem [REG_COUNT];

  function automatic logic [REG_W-1:0] seed_of(input int k);
    logic [REG_W-1:0] r;
    logic [3:0]       nib;
    nib = k[3:0];
    r   = '0;
    for (int n = 0; n < REG_W / 4; n++) r[n*4 +: 4] = nib;
    return r;
  endfunction

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < REG_COUNT; k++) mem[k] <= seed_of(k);
      dbg_data <= '0;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_data;
      dbg_data <= mem[dbg_sel];
    end
  end
endmodule

// File: rtl/rr_add_exec.sv
module rr_add_exec
  import insn_framer_pkg::*;
#(
  parameter int         BYTE_W     = 8,
  parameter int         REG_COUNT  = 16,
  parameter int         REG_W      = 32,
  parameter logic [7:0] ADD_OPCODE = 8'h1A,
  localparam int        IDX_W      = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [BYTE_W-1:0] opcode,
  input  logic [BYTE_W-1:0] reg_byte,
  input  fmt_e              insn_class,
  input  logic [IDX_W-1:0]  dbg_sel,
  output logic [REG_W-1:0]  dbg_data,
  output logic              add_done,
  output logic              add_ovf
);
  logic [IDX_W-1:0] dst_idx, src_idx;
  logic [REG_W-1:0] op_a, op_b, sum;
  logic             is_add, sgn_ovf;

  assign dst_idx = reg_byte[BYTE_W-1 -: IDX_W];
  assign src_idx = reg_byte[IDX_W-1:0];
  assign is_add  = insn_valid && (insn_class == FMT_RR) &&
                   (opcode == BYTE_W'(ADD_OPCODE));
  assign sum     = op_a + op_b;
  assign sgn_ovf = (op_a[REG_W-1] == op_b[REG_W-1]) &&
                   (sum[REG_W-1] != op_a[REG_W-1]);

  reg_bank #(.REG_COUNT(REG_COUNT), .REG_W(REG_W)) u_bank (
    .clk(clk), .rst(rst),
    .rd_a_idx(dst_idx), .rd_b_idx(src_idx),
    .rd_a(op_a), .rd_b(op_b),
    .wr_en(is_add), .wr_idx(dst_idx), .wr_data(sum),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      add_done <= 1'b0;
      add_ovf  <= 1'b0;
    end else begin
      add_done <= is_add;
      add_ovf  <= is_add && sgn_ovf;
    end
  end

  // R7: overflow is only reported alongside a completed add
  assert_ovf_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    add_ovf |-> add_done);

  // R6: an add completes only right after a framed instruction
  assert_done_follows_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !insn_valid |=> !add_done);
endmodule

// File: rtl/insn_framer.sv
module insn_framer
  import insn_framer_pkg::*;
#(
  parameter int         BYTE_W     = 8,
  parameter int         SHORT_LEN  = 2,
  parameter int         MID_LEN    = 4,
  parameter int         LONG_LEN   = 6,
  parameter int         REG_COUNT  = 16,
  parameter int         REG_W      = 32,
  parameter logic [7:0] ADD_OPCODE = 8'h1A,
  localparam int        LEN_W      = $clog2(LONG_LEN + 1),
  localparam int        INSN_W     = LONG_LEN * BYTE_W,
  localparam int        IDX_W      = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [INSN_W-1:0] out_insn,
  output logic [LEN_W-1:0]  out_len,
  output logic [2:0]        out_class,
  input  logic [IDX_W-1:0]  dbg_sel,
  output logic [REG_W-1:0]  dbg_data,
  output logic              add_done,
  output logic              add_ovf
);
  fmt_e cls;

  insn_assembler #(
    .BYTE_W(BYTE_W), .SHORT_LEN(SHORT_LEN), .MID_LEN(MID_LEN), .LONG_LEN(LONG_LEN)
  ) u_asm (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_insn(out_insn), .out_len(out_len),
    .out_class(cls)
  );

  assign out_class = cls;

  rr_add_exec #(
    .BYTE_W(BYTE_W), .REG_COUNT(REG_COUNT), .REG_W(REG_W), .ADD_OPCODE(ADD_OPCODE)
  ) u_exec (
    .clk(clk), .rst(rst),
    .insn_valid(out_valid),
    .opcode(out_insn[INSN_W-1 -: BYTE_W]),
    .reg_byte(out_insn[INSN_W-BYTE_W-1 -: BYTE_W]),
    .insn_class(cls),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .add_done(add_done), .add_ovf(add_ovf)
  );
endmodule

// File: tb/test_insn_framer.sv
module test_insn_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, out_valid, add_done, add_ovf;
  logic [47:0] out_insn;
  logic [2:0]  out_len, out_class;
  logic [3:0]  dbg_sel = 4'd0;
  logic [31:0] dbg_data;

  always #4 clk = ~clk;  // 125 MHz

  insn_framer i_insn_framer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_insn(out_insn),
    .out_len(out_len), .out_class(out_class), .dbg_sel(dbg_sel),
    .dbg_data(dbg_data), .add_done(add_done), .add_ovf(add_ovf)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_cnt, m_need;
  logic [2:0]  m_cls, m_cls_o, m_len;
  logic [47:0] m_buf, m_insn;
  bit          m_valid, m_done, m_ovf, m_ready;
  logic [31:0] m_regs [16];
  logic [31:0] m_dbg, ea, eb, es;
  int          ra, rb;

  function automatic logic [31:0] seed(input int k);
    logic [3:0] n;
    n = k[3:0];
    return {8{n}};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_need = 0; m_buf = '0; m_insn = '0; m_valid = 0;
      m_done = 0; m_ovf = 0; m_ready = 0; m_dbg = '0; m_len = '0; m_cls_o = '0;
      for (int k = 0; k < 16; k++) m_regs[k] = seed(k);
    end else begin
      m_dbg  = m_regs[dbg_sel];
      m_done = 0;
      m_ovf  = 0;
      if (m_valid && m_insn[47:40] == 8'h1A) begin
        ra = int'(m_insn[39:36]);
        rb = int'(m_insn[35:32]);
        ea = m_regs[ra];
        eb = m_regs[rb];
        es = ea + eb;
        m_regs[ra] = es;
        m_done = 1;
        m_ovf  = (ea[31] == eb[31]) && (es[31] != ea[31]);
      end
      m_valid = 0;
      if (in_valid && m_ready) begin
        if (m_cnt == 0) begin
          m_buf = '0;
          m_buf[47:40] = in_data;
          case (in_data[7:6])
            2'b00: begin m_need = 2; m_cls = 3'd0; end
            2'b01: begin m_need = 4; m_cls = 3'd2; end
            2'b10: begin m_need = 4; m_cls = in_data[5] ? 3'd3 : 3'd1; end
            default: begin m_need = 6; m_cls = 3'd4; end
          endcase
          m_cnt = 1;
        end else begin
          m_buf[47-8*m_cnt -: 8] = in_data;
          m_cnt++;
          if (m_cnt == m_need) begin
            m_valid = 1; m_insn = m_buf; m_len = 3'(m_need);
            m_cls_o = m_cls; m_cnt = 0;
          end
        end
      end
      m_ready = 1;
    end
  end

  // ---------------- comparison every cycle ----------------
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(in_ready === m_ready, "R5 in_ready", 64'(in_ready), 64'(m_ready));
      check(out_valid === m_valid, "R4 out_valid", 64'(out_valid), 64'(m_valid));
      if (m_valid) begin
        check(out_insn === m_insn, "R4 out_insn", 64'(out_insn), 64'(m_insn));
        check(out_len === m_len, "R2 out_len", 64'(out_len), 64'(m_len));
        check(out_class === m_cls_o, "R3 out_class", 64'(out_class), 64'(m_cls_o));
      end
      check(add_done === m_done, "R6 add_done", 64'(add_done), 64'(m_done));
      check(add_ovf === m_ovf, "R7 add_ovf", 64'(add_ovf), 64'(m_ovf));
      check(dbg_data === m_dbg, "R8 dbg_data (R6 register contents)",
            64'(dbg_data), 64'(m_dbg));
    end
  end

  // debug index sweep
  initial begin
    forever begin
      @(negedge clk);
      dbg_sel = dbg_sel + 4'd1;
    end
  end

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_gap(input logic [7:0] b);
    push(b);
    idle(1);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready === 1'b0, "R1 in_ready in reset", 64'(in_ready), 64'd0);
    check(out_valid === 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    check(add_done === 1'b0, "R1 add_done in reset", 64'(add_done), 64'd0);
    check(dbg_data === 32'd0, "R1 dbg_data in reset", 64'(dbg_data), 64'd0);
    rst = 1'b0;
    idle(20);  // sweep shows every R1 seed value through R8
    // R6: adds, some with stalls between bytes
    push(8'h1A); push(8'h68);
    push_gap(8'h1A); push_gap(8'hAB);
    push(8'h1A); push(8'h77);          // R7: positive overflow
    push(8'h1A); idle(3); push(8'h89); // R7: negative overflow
    push(8'h1A); push(8'h66);          // neg + neg, no overflow
    // R6: other two-byte opcodes leave registers alone
    push(8'h18); push(8'h12);
    push(8'h3F); push(8'h00);
    // R2/R3: four-byte classes
    push(8'h41); push(8'h23); push(8'h45); push(8'h67);
    push_gap(8'h90); push_gap(8'h11); push_gap(8'h22); push_gap(8'h33);
    push(8'hA5); push(8'h44); push(8'h55); push(8'h66);
    // six-byte class
    push(8'hD2); push(8'h01); push(8'h02); push(8'h03); push(8'h04); push(8'h05);
    push(8'hFF); idle(2); push(8'hEE); push(8'hDD); push(8'hCC); push(8'hBB); push(8'hAA);
    // back-to-back adds with no stall
    push(8'h1A); push(8'h12); push(8'h1A); push(8'h21);
    idle(20);
    // R1: reset in the middle of a four-byte instruction
    push(8'h45); push(8'h01);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    push(8'h1A); push(8'h12);  // must frame as a two-byte add
    idle(20);
    finished = 1'b1;
    report();
    $finish;
  end
endmodule